// File: doc/BRIEF.md
# Gated Free-Running Timer

This block is a 16-bit up-counter that advances once per clock while it is allowed to run. A small control register decides when it may run. It holds a global enable, a stop-on-wait bit and a stop-on-freeze bit. These bits are combined with the system's wait and freeze mode inputs. A separate 6-bit divider runs beside the counter and produces a one-cycle pulse every 64 active cycles, which a pulse accumulator elsewhere uses as its clock tick. The two halt conditions treat that tick differently. A wait halt stops both the counter and the divider. A freeze halt stops only the counter, and the divider keeps ticking.

Gating is decided by a four-state machine that is recomputed every cycle from the control bits and the mode inputs. In ST_OFF the enable bit is clear and everything is stopped. ST_RUN is normal counting. In ST_WAIT_HALT the stop-on-wait bit and the wait input are both high, and everything is stopped. In ST_FRZ_HALT the stop-on-freeze bit and the freeze input are both high and the wait halt does not apply, so only the counter stops. Every state can move to every other state in one edge. The transitions go_off, go_run, go_wait_halt and go_frz_halt are named after their target and are taken whenever their condition holds. go_off has the highest priority, then go_wait_halt, then go_frz_halt, and go_run is taken otherwise. A write to the counter is honoured only while the test-mode input is high. Such a write leaves the divider phase untouched.

Top module: `frt_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the counter reads 0x0000, and both the overflow and tick outputs are low.
- R2: A write with reg_sel=0 stores data bits 7 (enable), 6 (stop-on-wait) and 5 (stop-on-freeze). A read with reg_sel=0 returns those bits in the same positions and 0 in every other bit, so writing 0xFFFF reads back 0x00E0.
- R3: In ST_RUN the counter rises by exactly one per clock. A control write or mode change alters the gating from the second rising edge after it, so a counter held at V before an enabling write still reads V after the first edge and V+1 after the second.
- R4: With the enable bit 0 the counter holds its value and no tick is produced, whatever the mode inputs are.
- R5: With stop-on-wait 1 and wait high, the counter holds and no tick is produced. If only one of the two is high, counting and ticks continue. This halt takes priority over the freeze halt.
- R6: With stop-on-freeze 1 and freeze high (and no wait halt), the counter holds while the tick keeps arriving every 64 cycles.
- R7: A write with reg_sel=1 while test=0 leaves the counter unchanged. With test=1 the counter reads the written value after the write edge and counts on from it.
- R8: A counter write does not reset the tick divider, so tick spacing across the write stays 64 cycles.
- R9: When the counter steps from 0xFFFF to 0x0000, overflow is high for exactly the one cycle in which the counter reads 0x0000.
- R10: While the divider runs, tick is a one-cycle pulse with exactly 64 cycles between rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 control, 1 counter |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| mode_wait | input | 1 | System wait mode |
| mode_freeze | input | 1 | System freeze (debug) mode |
| mode_test | input | 1 | Test/special mode, permits counter writes |
| cnt_value | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |
| tick64 | output | 1 | One-cycle divide-by-64 tick for a pulse accumulator |

## Verification
A wrong gating state shows up at the ports within two edges of its cause. A counter that creeps while it should hold, or stalls while it should run, differs from the expected value after a single cycle. A tick that is wrongly stopped or kept running is visible within one 64-cycle tick period, because each window is measured over 128 cycles. A divider whose phase is disturbed by a counter write moves the next tick away from its 64-cycle slot. An overflow raised at the wrong value is visible in the exact cycle the counter passes zero.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;
    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_RUN       = 2'd1,
        ST_WAIT_HALT = 2'd2,
        ST_FRZ_HALT  = 2'd3
    } run_state_t;

    localparam int CTRL_W   = 8;
    localparam int BIT_EN   = 7;
    localparam int BIT_SWAI = 6;
    localparam int BIT_SFRZ = 5;
endpackage

// File: rtl/frt_ctrl.sv
`timescale 1ns/1ps
module frt_ctrl
    import frt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_wait,
    input  logic              mode_freeze,
    output logic [CTRL_W-1:0] ctrl_rd,
    output run_state_t        st_q,
    output logic              cnt_run,
    output logic              pre_run
);
    logic       en_q;
    logic       swai_q;
    logic       sfrz_q;
    run_state_t st_d;

    // control bits: only the three implemented positions are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            swai_q <= 1'b0;
            sfrz_q <= 1'b0;
        end else if (ctrl_we) begin
            en_q   <= wr_data[BIT_EN];
            swai_q <= wr_data[BIT_SWAI];
            sfrz_q <= wr_data[BIT_SFRZ];
        end
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[BIT_EN]   = en_q;
        ctrl_rd[BIT_SWAI] = swai_q;
        ctrl_rd[BIT_SFRZ] = sfrz_q;
    end

    // next-state: go_off > go_wait_halt > go_frz_halt > go_run
    always_comb begin
        if (!en_q)
            st_d = ST_OFF;
        else if (swai_q && mode_wait)
            st_d = ST_WAIT_HALT;
        else if (sfrz_q && mode_freeze)
            st_d = ST_FRZ_HALT;
        else
            st_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    // gating outputs per state
    always_comb begin
        unique case (st_q)
            ST_OFF: begin
                cnt_run = 1'b0;
                pre_run = 1'b0;
            end
            ST_RUN: begin
                cnt_run = 1'b1;
                pre_run = 1'b1;
            end
            ST_WAIT_HALT: begin
                cnt_run = 1'b0;
                pre_run = 1'b0;
            end
            ST_FRZ_HALT: begin
                cnt_run = 1'b0;
                pre_run = 1'b1;
            end
            default: begin
                cnt_run = 1'b0;
                pre_run = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/frt_count.sv
`timescale 1ns/1ps
module frt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_top;
    assign at_top = &cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            ovf_q <= 1'b0;
        end else if (run) begin
            cnt_q <= cnt_q + ONE;
            ovf_q <= at_top;
        end else begin
            ovf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frt_presc.sv
`timescale 1ns/1ps
module frt_presc #(
    parameter int DIV_BITS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick_q
);
    localparam logic [DIV_BITS-1:0] ONE = {{(DIV_BITS-1){1'b0}}, 1'b1};

    logic [DIV_BITS-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= run && (&div_q);
            if (run)
                div_q <= div_q + ONE;
        end
    end
endmodule

// File: rtl/frt_timer.sv
`timescale 1ns/1ps
module frt_timer
    import frt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_BITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             mode_wait,
    input  logic             mode_freeze,
    input  logic             mode_test,
    output logic [CNT_W-1:0] cnt_value,
    output logic             ovf_pulse,
    output logic             tick64
);
    localparam int PAD_W = CNT_W - CTRL_W;

    logic              ctrl_we;
    logic              cnt_load;
    logic [CTRL_W-1:0] ctrl_rd;
    run_state_t        st_q;
    logic              cnt_run;
    logic              pre_run;

    assign ctrl_we  = wr_en && !reg_sel;
    assign cnt_load = wr_en && reg_sel && mode_test;

    frt_ctrl #(.DATA_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .wr_data    (wr_data),
        .mode_wait  (mode_wait),
        .mode_freeze(mode_freeze),
        .ctrl_rd    (ctrl_rd),
        .st_q       (st_q),
        .cnt_run    (cnt_run),
        .pre_run    (pre_run)
    );

    frt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_run),
        .load    (cnt_load),
        .load_val(wr_data),
        .cnt_q   (cnt_value),
        .ovf_q   (ovf_pulse)
    );

    frt_presc #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pre_run),
        .tick_q(tick64)
    );

    assign rd_data = reg_sel ? cnt_value : {{PAD_W{1'b0}}, ctrl_rd};
endmodule

// File: rtl/frt_timer_chk.sv
`timescale 1ns/1ps
module frt_timer_chk
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] cnt_value,
    input logic             ovf_pulse,
    input logic             tick64,
    input logic             cnt_load,
    input run_state_t       st_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_ctrl_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (rd_data[CNT_W-1:CTRL_W] == '0 && rd_data[4:0] == '0));

    p_run_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !cnt_load) |=> cnt_value == $past(cnt_value) + ONE);

    // covers R4, R5 and R6: any non-running state freezes the counter
    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && !cnt_load) |=> $stable(cnt_value));

    p_no_tick_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF || st_q == ST_WAIT_HALT) |=> !tick64);

    p_ovf_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pulse) |-> (cnt_value == '0 && $past(cnt_value) == '1));

    p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

    p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick64 |=> !tick64);
endmodule

bind frt_timer frt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .rd_data  (rd_data),
    .cnt_value(cnt_value),
    .ovf_pulse(ovf_pulse),
    .tick64   (tick64),
    .cnt_load (cnt_load),
    .st_q     (st_q)
);

// File: tb/sim_frt_timer.sv
`timescale 1ns/1ps
module sim_frt_timer;
    localparam int WIN = 128;
    localparam int NV  = 10;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic        w;
        logic        f;
        logic [15:0] delta;
        logic [3:0]  ticks;
        logic [3:0]  req;
    } vec_t;

    // ctrl, wait, freeze, expected counter delta over WIN, expected ticks, requirement
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b0, 1'b0, 16'd0,   4'd0, 4'd4},
        '{8'h80, 1'b0, 1'b0, 16'd128, 4'd2, 4'd3},
        '{8'hC0, 1'b1, 1'b0, 16'd0,   4'd0, 4'd5},
        '{8'hC0, 1'b0, 1'b0, 16'd128, 4'd2, 4'd5},
        '{8'h80, 1'b1, 1'b0, 16'd128, 4'd2, 4'd5},
        '{8'hA0, 1'b0, 1'b1, 16'd0,   4'd2, 4'd6},
        '{8'hA0, 1'b0, 1'b0, 16'd128, 4'd2, 4'd6},
        '{8'hE0, 1'b1, 1'b1, 16'd0,   4'd0, 4'd5},
        '{8'h80, 1'b0, 1'b1, 16'd128, 4'd2, 4'd6},
        '{8'h20, 1'b0, 1'b1, 16'd0,   4'd0, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        mode_wait = 1'b0;
    logic        mode_freeze = 1'b0;
    logic        mode_test = 1'b0;
    logic [15:0] cnt_value;
    logic        ovf_pulse;
    logic        tick64;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frt_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .mode_wait  (mode_wait),
        .mode_freeze(mode_freeze),
        .mode_test  (mode_test),
        .cnt_value  (cnt_value),
        .ovf_pulse  (ovf_pulse),
        .tick64     (tick64)
    );

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] data);
        @(negedge clk);
        reg_sel = sel;
        wr_data = data;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] val);
        reg_sel = sel;
        #1;
        val = rd_data;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] v0;
        logic [15:0] prev;
        int          tcnt;
        int          tick_at;
        int          zero_at;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v);
        check("R1 ctrl", 32'(v), 32'h0);
        rd(1'b1, v);
        check("R1 cnt", 32'(v), 32'h0);
        check("R1 ovf", 32'(ovf_pulse), 32'h0);
        check("R1 tick", 32'(tick64), 32'h0);

        // vector table walk: steady-state gating over a window
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_wait   = VECS[i].w;
            mode_freeze = VECS[i].f;
            wr(1'b0, {8'h00, VECS[i].ctrl});
            repeat (3) @(negedge clk);
            v0   = cnt_value;
            tcnt = 0;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                if (tick64) tcnt++;
            end
            check(req_name(VECS[i].req), 32'(cnt_value - v0), 32'(VECS[i].delta));
            check(VECS[i].ticks == 0 ? req_name(VECS[i].req) : "R10", 32'(tcnt), 32'(VECS[i].ticks));
        end
        mode_wait   = 1'b0;
        mode_freeze = 1'b0;

        // R2 unimplemented bits
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v);
        check("R2 ctrl all-ones", 32'(v), 32'h00E0);
        wr(1'b0, 16'h0000);
        rd(1'b0, v);
        check("R2 ctrl cleared", 32'(v), 32'h0000);

        // R7 counter writes: ignored in normal mode, loaded in test mode
        repeat (2) @(negedge clk);
        v0 = cnt_value;
        wr(1'b1, v0 ^ 16'h1234);
        check("R7 ignored", 32'(cnt_value), 32'(v0));
        mode_test = 1'b1;
        wr(1'b1, 16'h1234);
        mode_test = 1'b0;
        check("R7 loaded", 32'(cnt_value), 32'h1234);

        // R3 two-edge latency of an enabling write
        mode_test = 1'b1;
        wr(1'b1, 16'h0100);
        mode_test = 1'b0;
        wr(1'b0, 16'h0080);
        check("R3 after write edge", 32'(cnt_value), 32'h0100);
        @(negedge clk);
        check("R3 after 1st edge", 32'(cnt_value), 32'h0100);
        @(negedge clk);
        check("R3 after 2nd edge", 32'(cnt_value), 32'h0101);

        // R8 divider phase kept across a counter write; R7 load while running
        tick_at = 0;
        for (int c = 0; c < 100 && tick_at == 0; c++) begin
            @(negedge clk);
            if (tick64) tick_at = 1;
        end
        tick_at = 0;
        for (int c = 1; c <= 80 && tick_at == 0; c++) begin
            @(negedge clk);
            if (tick64) tick_at = c;
            if (c == 11) begin
                check("R7 load while running", 32'(cnt_value), 32'h4000);
                wr_en     = 1'b0;
                mode_test = 1'b0;
            end
            if (c == 10) begin
                mode_test = 1'b1;
                reg_sel   = 1'b1;
                wr_data   = 16'h4000;
                wr_en     = 1'b1;
            end
        end
        check("R8 tick spacing across write", 32'(tick_at), 32'd64);

        // R10 pulse width and spacing
        @(negedge clk);
        check("R10 width", 32'(tick64), 32'h0);
        tick_at = 0;
        for (int c = 2; c <= 80 && tick_at == 0; c++) begin
            @(negedge clk);
            if (tick64) tick_at = c;
        end
        check("R10 spacing", 32'(tick_at), 32'd64);

        // R9 wrap and overflow pulse
        wr(1'b0, 16'h0000);
        mode_test = 1'b1;
        wr(1'b1, 16'hFFFD);
        mode_test = 1'b0;
        wr(1'b0, 16'h0080);
        zero_at = 0;
        prev    = cnt_value;
        tcnt    = 0;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (ovf_pulse) tcnt++;
            if (cnt_value == 16'h0000 && zero_at == 0) begin
                zero_at = c;
                check("R9 ovf at zero", 32'(ovf_pulse), 32'h1);
                check("R9 prior value", 32'(prev), 32'hFFFF);
            end
            prev = cnt_value;
        end
        check("R9 zero reached", 32'(zero_at != 0), 32'h1);
        check("R9 single pulse", 32'(tcnt), 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule